// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Pin Conditioning

This block gathers interrupt requests and presents one winner at a time to a processor core. The winner is shown as a source number and a 16-bit vector address. Requests come from eight external pins and eight on-chip device sources. They also come from three fixed sources: watchdog, divide-by-zero and address match. A further built-in request stands for the reset itself and is raised by the block's own reset. Each external pin passes through a two-flop synchronizer. A per-pin setting chooses level or edge detection, and a second setting chooses the active polarity. The synchronized pin levels are also available as an 8-bit status output.

The external pins and device sources are maskable. Each has a request flag and a 3-bit priority level, both written through a simple configuration write port. The fixed sources have no level and ignore the processor's masking inputs. They outrank every maskable source in a fixed order. The core takes an interrupt by pulsing `irq_ack` while `irq_valid` is high. That clears the flag of the presented source, and the next winner appears on the outputs in the same edge.

Top module: `irq_ctrl`

## Requirements
- R1: `ext_edge[i]` selects the detector for pin i. A value of 1 gives edge detection. A value of 0 gives level detection, where the request flag is set on every cycle that the synchronized pin is at its active level.
- R2: For pin i, `ext_pol[i]`=1 makes high the active level (rising edge in edge mode), and 0 makes low the active level (falling edge in edge mode). In edge mode each detected transition sets the request flag exactly once. A pin that is then held steady raises nothing more once its request has been taken.
- R3: `pin_status[i]` shows the level of `ext_pin[i]` as it stood two clock edges earlier.
- R4: Acceptance (`irq_ack`=1 while `irq_valid`=1) clears the request flag of source `irq_id`. A level-mode pin that is still active sets the flag again and is presented again one edge later.
- R5: A configuration write (`cfg_we`=1) with `cfg_req`=0 clears the flag of source `cfg_sel`, and with `cfg_req`=1 leaves it unchanged. Writes that address the reset source (id 0) or the watchdog (id 1) never clear their flags.
- R6: The fixed sources win in the order reset (0), watchdog (1), divide-by-zero (2), address match (3), and each of them wins over any maskable source, whatever the values of `cpu_ipl` and `cpu_idis`.
- R7: While `rst_n` is low, `irq_valid` is 0. The reset source is pending when reset is released, so the first clock edge afterwards presents id 0.
- R8: Source ids are: 0 reset, 1 watchdog, 2 divide-by-zero, 3 address match, 4+i external pin i, 12+j device source j. The vector is 0xFFFE minus twice the id, which is the low-byte address of a two-byte entry.
- R9: A configuration write stores `cfg_lvl` as the priority level of a maskable source (id 4 or above). Levels reset to 0, and a level of 0 keeps that source from ever winning.
- R10: A maskable source can win only if its level is strictly greater than `cpu_ipl` and `cpu_idis` is 0.
- R11: Among the eligible maskable sources, the highest level wins. On equal levels the lower id wins, which is the higher vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | External interrupt pins, asynchronous |
| ext_edge | input | 8 | Per-pin detector select: 1 edge, 0 level |
| ext_pol | input | 8 | Per-pin polarity: 1 high/rising, 0 low/falling |
| pin_status | output | 8 | Synchronized pin levels |
| wdt_req | input | 1 | Watchdog request pulse |
| div0_req | input | 1 | Divide-by-zero request pulse |
| amatch_req | input | 1 | Address-match request pulse |
| dev_req | input | 8 | On-chip device request pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Source id addressed by the write |
| cfg_lvl | input | 3 | Priority level written to a maskable source |
| cfg_req | input | 1 | Request bit written; 0 clears the flag |
| cpu_ipl | input | 3 | Processor's current priority level |
| cpu_idis | input | 1 | Global disable for maskable sources |
| irq_ack | input | 1 | Acceptance of the presented request |
| irq_valid | output | 1 | A request is presented |
| irq_id | output | 5 | Id of the presented source |
| irq_vector | output | 16 | Vector low-byte address of the presented source |

## Verification
Device and fixed-source pulses set their flags on the edge that samples them, and the outputs show the new winner one edge later. A pin change takes two edges to reach `pin_status` and four edges to reach the outputs. After an acceptance or a change to `cpu_ipl`/`cpu_idis`, the outputs change on the very next edge. A clearing configuration write takes effect one edge after its own. The bench drives inputs just after a rising edge and then advances exactly those edge counts. It then queues the expected id, vector or status, and its monitor compares the queued item on the following falling edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // fixed source ids; their order is the hardware priority order
  localparam int ID_RESET  = 0;
  localparam int ID_WDT    = 1;
  localparam int ID_DIV0   = 2;
  localparam int ID_AMATCH = 3;
  localparam int N_FIXED   = 4;
endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic pol,
  output logic level_q,
  output logic req_set
);
  logic sync1_q, sync2_q, prev_q;
  logic active, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    active   = (sync2_q == pol);
    edge_hit = (sync2_q != prev_q) && active;
    req_set  = edge_mode ? edge_hit : active;
    level_q  = sync2_q;
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
#(
  parameter int NS    = 20,
  parameter int LVL_W = 3,
  parameter int SEL_W = 5,
  localparam int NM   = NS - N_FIXED
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NS-1:0]             set_vec,
  input  logic [NS-1:0]             ack_clr,
  input  logic                      cfg_we,
  input  logic [SEL_W-1:0]          cfg_sel,
  input  logic [LVL_W-1:0]          cfg_lvl,
  input  logic                      cfg_req,
  output logic [NS-1:0]             pend,
  output logic [NM-1:0][LVL_W-1:0]  lvl
);
  logic [NS-1:0]            sw_clr;
  logic [NS-1:0]            pend_n;
  logic [NM-1:0][LVL_W-1:0] lvl_n;
  logic [NM-1:0]            lvl_en;

  always_comb begin
    sw_clr = '0;
    // reset and watchdog flags are not reachable by software clears
    for (int i = ID_DIV0; i < NS; i++) begin
      if (cfg_we && !cfg_req && cfg_sel == SEL_W'(i)) sw_clr[i] = 1'b1;
    end
    // a new request in the same edge survives a clear
    pend_n = (pend & ~ack_clr & ~sw_clr) | set_vec;
  end

  always_comb begin
    for (int j = 0; j < NM; j++) begin
      lvl_en[j] = cfg_we && (cfg_sel == SEL_W'(j + N_FIXED));
      lvl_n[j]  = cfg_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= NS'(1) << ID_RESET;
    else        pend <= pend_n;
  end

  for (genvar g = 0; g < NM; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lvl[g] <= '0;
      else if (lvl_en[g]) lvl[g] <= lvl_n[g];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NS    = 20,
  parameter int LVL_W = 3,
  parameter int SEL_W = 5,
  localparam int NM   = NS - N_FIXED
) (
  input  logic [NS-1:0]             pend,
  input  logic [NS-1:0]             drop,
  input  logic [NM-1:0][LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]          cpu_ipl,
  input  logic                      cpu_idis,
  output logic                      win_valid,
  output logic [SEL_W-1:0]          win_id
);
  logic [NS-1:0]    live;
  logic             fix_found, msk_found;
  logic [SEL_W-1:0] fix_id, msk_id;
  logic [LVL_W-1:0] best_lvl;

  always_comb begin
    live = pend & ~drop;

    fix_found = 1'b0;
    fix_id    = '0;
    for (int i = N_FIXED - 1; i >= 0; i--) begin
      if (live[i]) begin
        fix_found = 1'b1;
        fix_id    = SEL_W'(i);
      end
    end

    // strict compare keeps the lowest id on equal levels
    msk_found = 1'b0;
    msk_id    = '0;
    best_lvl  = '0;
    for (int j = 0; j < NM; j++) begin
      if (live[j + N_FIXED] && !cpu_idis && lvl[j] > cpu_ipl && lvl[j] > best_lvl) begin
        msk_found = 1'b1;
        msk_id    = SEL_W'(j + N_FIXED);
        best_lvl  = lvl[j];
      end
    end

    win_valid = fix_found || msk_found;
    win_id    = fix_found ? fix_id : msk_id;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_EXT        = 8,
  parameter int N_DEV        = 8,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE,
  localparam int NS          = N_FIXED + N_EXT + N_DEV,
  localparam int SEL_W       = $clog2(NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [N_EXT-1:0]  ext_edge,
  input  logic [N_EXT-1:0]  ext_pol,
  output logic [N_EXT-1:0]  pin_status,
  input  logic              wdt_req,
  input  logic              div0_req,
  input  logic              amatch_req,
  input  logic [N_DEV-1:0]  dev_req,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [LVL_W-1:0]  cfg_lvl,
  input  logic              cfg_req,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic              cpu_idis,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [SEL_W-1:0]  irq_id,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam int NM = NS - N_FIXED;

  logic [N_EXT-1:0]         ext_set;
  logic [NS-1:0]            set_vec;
  logic [NS-1:0]            ack_clr;
  logic [NS-1:0]            pend;
  logic [NM-1:0][LVL_W-1:0] lvl;
  logic                     win_valid;
  logic [SEL_W-1:0]         win_id;
  logic                     valid_n;
  logic [SEL_W-1:0]         id_n;
  logic [VEC_W-1:0]         vec_n;

  for (genvar p = 0; p < N_EXT; p++) begin : g_pin
    irq_pin_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (ext_pin[p]),
      .edge_mode (ext_edge[p]),
      .pol       (ext_pol[p]),
      .level_q   (pin_status[p]),
      .req_set   (ext_set[p])
    );
  end

  always_comb begin
    set_vec = {dev_req, ext_set, amatch_req, div0_req, wdt_req, 1'b0};
    ack_clr = '0;
    for (int i = 0; i < NS; i++) begin
      if (irq_ack && irq_valid && irq_id == SEL_W'(i)) ack_clr[i] = 1'b1;
    end
  end

  irq_flags #(.NS(NS), .LVL_W(LVL_W), .SEL_W(SEL_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .ack_clr (ack_clr),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .cfg_lvl (cfg_lvl),
    .cfg_req (cfg_req),
    .pend    (pend),
    .lvl     (lvl)
  );

  irq_arbiter #(.NS(NS), .LVL_W(LVL_W), .SEL_W(SEL_W)) u_arb (
    .pend      (pend),
    .drop      (ack_clr),
    .lvl       (lvl),
    .cpu_ipl   (cpu_ipl),
    .cpu_idis  (cpu_idis),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  always_comb begin
    valid_n = win_valid;
    id_n    = win_id;
    vec_n   = VEC_W'(VEC_TOP) - (VEC_W'(win_id) << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_id     <= '0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= valid_n;
      irq_id     <= id_n;
      irq_vector <= vec_n;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NS    = 20,
  parameter int SEL_W = 5,
  parameter int VEC_W = 16,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_idis,
  input logic             irq_ack,
  input logic             irq_valid,
  input logic [SEL_W-1:0] irq_id,
  input logic [VEC_W-1:0] irq_vector,
  input logic [NS-1:0]    pend
);
  // R8: vectors are even and stay inside the table
  a_r8_vec_even: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[0] == 1'b0 &&
                   irq_vector >= VEC_W'(VEC_TOP) - VEC_W'(2 * (NS - 1))));

  // R5: a presented watchdog request stays until accepted
  a_r5_wdt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id == SEL_W'(1) && !irq_ack) |=>
      (irq_valid && irq_id <= SEL_W'(1)));

  // R6: maskable winner only when no fixed source was pending
  a_r6_fixed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id >= SEL_W'(4) && $past(!irq_ack)) |->
      $past(pend[3:0] == 4'b0000));

  // R10: maskable winner only while the global disable was clear
  a_r10_idis_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_id >= SEL_W'(4)) |-> $past(!cpu_idis));

  // R4: an accepted source is not presented on the next cycle
  a_r4_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid) |=> !(irq_valid && irq_id == $past(irq_id)));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NS(NS), .SEL_W(SEL_W), .VEC_W(VEC_W), .VEC_TOP(VEC_TOP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_idis   (cpu_idis),
  .irq_ack    (irq_ack),
  .irq_valid  (irq_valid),
  .irq_id     (irq_id),
  .irq_vector (irq_vector),
  .pend       (pend)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ext_pin, ext_edge, ext_pol, pin_status;
  logic        wdt_req, div0_req, amatch_req;
  logic [7:0]  dev_req;
  logic        cfg_we, cfg_req;
  logic [4:0]  cfg_sel;
  logic [2:0]  cfg_lvl, cpu_ipl;
  logic        cpu_idis, irq_ack;
  logic        irq_valid;
  logic [4:0]  irq_id;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit    is_stat;
    bit    valid;
    int    id;
    int    stat;
    string tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_edge(ext_edge),
    .ext_pol(ext_pol), .pin_status(pin_status), .wdt_req(wdt_req),
    .div0_req(div0_req), .amatch_req(amatch_req), .dev_req(dev_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lvl(cfg_lvl), .cfg_req(cfg_req),
    .cpu_ipl(cpu_ipl), .cpu_idis(cpu_idis), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_vector(irq_vector)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.is_stat) begin
        if (pin_status !== 8'(it.stat)) begin
          errors++;
          $display("FAIL %s: pin_status=%h expected %h", it.tag, pin_status, 8'(it.stat));
        end
      end else if (!it.valid) begin
        if (irq_valid !== 1'b0) begin
          errors++;
          $display("FAIL %s: irq_valid=%b id=%0d expected valid=0", it.tag, irq_valid, irq_id);
        end
      end else begin
        logic [15:0] ev;
        ev = 16'hFFFE - 16'(2 * it.id);
        if (irq_valid !== 1'b1 || irq_id !== 5'(it.id) || irq_vector !== ev) begin
          errors++;
          $display("FAIL %s: valid=%b id=%0d vec=%h expected valid=1 id=%0d vec=%h",
                   it.tag, irq_valid, irq_id, irq_vector, it.id, ev);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_irq(input int id, input string tag);
    item_t it;
    it.is_stat = 0; it.valid = 1; it.id = id; it.stat = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_none(input string tag);
    item_t it;
    it.is_stat = 0; it.valid = 0; it.id = 0; it.stat = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_stat(input int v, input string tag);
    item_t it;
    it.is_stat = 1; it.valid = 0; it.id = 0; it.stat = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic cfg_write(input int sel, input int lv, input bit rq);
    cfg_we = 1; cfg_sel = 5'(sel); cfg_lvl = 3'(lv); cfg_req = rq;
    tick(1);
    cfg_we = 0; cfg_req = 1;
  endtask

  task automatic accept();
    irq_ack = 1;
    tick(1);
    irq_ack = 0;
  endtask

  task automatic finish_run();
    tick(1);
    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_pin = 8'h04; ext_edge = 8'b1111_1010; ext_pol = 8'b1111_1001;
    wdt_req = 0; div0_req = 0; amatch_req = 0; dev_req = '0;
    cfg_we = 0; cfg_sel = '0; cfg_lvl = '0; cfg_req = 1;
    cpu_ipl = '0; cpu_idis = 0; irq_ack = 0;
    tick(3);
    exp_none("R7 reset state");
    tick(1);

    // boot: reset source beats a simultaneous watchdog pulse
    rst_n = 1; wdt_req = 1;
    tick(1);
    wdt_req = 0;
    exp_irq(0, "R7 R6 reset source first");
    accept();
    exp_irq(1, "R6 R8 watchdog next");
    cfg_write(1, 0, 0);
    tick(1);
    exp_irq(1, "R5 watchdog ignores clear");
    accept();
    exp_none("R4 watchdog accepted");

    // levels for device and pin sources
    cfg_write(12, 3, 1);
    cfg_write(13, 5, 1);
    cfg_write(14, 5, 1);
    cfg_write(4, 2, 1);
    cfg_write(5, 4, 1);
    div0_req = 1; amatch_req = 1; dev_req = 8'b0000_0111;
    tick(1);
    div0_req = 0; amatch_req = 0; dev_req = '0;
    tick(1);
    exp_irq(2, "R6 divide-by-zero over rest");
    accept();
    exp_irq(3, "R6 address match next");
    accept();
    exp_irq(13, "R11 tie goes to lower id");
    cpu_idis = 1;
    tick(1);
    exp_none("R10 global disable");
    cpu_idis = 0; cpu_ipl = 5;
    tick(1);
    exp_none("R10 level equal to ipl");
    cpu_ipl = 4;
    tick(1);
    exp_irq(13, "R10 level above ipl");
    accept();
    exp_irq(14, "R4 R11 second of tie");
    accept();
    exp_none("R10 level 3 below ipl 4");
    cpu_ipl = 0;
    tick(1);
    exp_irq(12, "R11 remaining device");
    cfg_write(12, 3, 1);
    tick(1);
    exp_irq(12, "R5 writing 1 keeps flag");
    cfg_write(12, 3, 0);
    tick(1);
    exp_none("R5 software clear");
    cfg_write(13, 0, 1);
    dev_req = 8'b0000_0010;
    tick(1);
    dev_req = '0;
    tick(1);
    exp_none("R9 level 0 disables");

    // pin 0: level, active high
    ext_pin[0] = 1;
    tick(2);
    exp_stat(8'h05, "R3 status pin0 high");
    tick(2);
    exp_irq(4, "R1 level pin request");
    accept();
    exp_none("R4 accepted level pin");
    tick(1);
    exp_irq(4, "R4 level pin re-raised");
    ext_pin[0] = 0;
    tick(3);
    accept();
    exp_none("R4 accept after pin drop");
    tick(1);
    exp_none("R1 level pin stays quiet");

    // pin 1: edge, falling
    ext_pin[1] = 1;
    tick(2);
    exp_stat(8'h06, "R3 status pin1 high");
    tick(3);
    exp_none("R2 rising edge ignored");
    ext_pin[1] = 0;
    tick(4);
    exp_irq(5, "R2 falling edge request");
    accept();
    exp_none("R2 edge accepted");
    tick(3);
    exp_none("R2 one request per edge");

    // pin 2: level, active low
    cfg_write(6, 6, 0);
    tick(1);
    exp_none("R5 pin2 stale flag cleared");
    ext_pin[2] = 0;
    tick(4);
    exp_irq(6, "R2 active-low level");
    cfg_write(6, 0, 1);
    tick(1);
    exp_none("R9 level set to 0");

    // pin 7 and device 7 tie at level 7
    cfg_write(11, 7, 1);
    ext_pin[7] = 1;
    tick(4);
    exp_irq(11, "R8 pin7 vector");
    cfg_write(19, 7, 1);
    dev_req[7] = 1;
    tick(1);
    dev_req[7] = 0;
    exp_irq(11, "R11 pin beats device on tie");
    accept();
    exp_irq(19, "R8 device7 vector");
    accept();
    exp_none("R4 all taken");

    done = 1;
    finish_run();
  end
endmodule